// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector

This block compares a reference square wave against a divided feedback square wave and reports which one leads. It runs on a fast system clock that is much faster than either input. Both inputs are brought into the clock domain through a two-flop synchroniser, and their rising edges are found there.

A rising edge on either input sets a flag for that side. The reference flag drives the up output and the feedback flag drives the down output. A flag that is set stays set until the other side catches up. At that point both flags stay high together for a programmable number of cycles and then clear on the same edge. As a result, each output pulse lasts for the lead of its input plus the overlap time.

A third output reports when both flags are low. Over many cycles, a frequency difference shows up as one output being active far more often than the other.

Top module: `pfd_tristate`

## Requirements
- R1: If `ref_in` is sampled low at one clock edge and high at the next edge k, then `up_o` is high after edge k+2, unless both outputs are already high at that time.
- R2: If `fb_in` is sampled low at one clock edge and high at the next edge k, then `dn_o` is high after edge k+2, unless both outputs are already high at that time.
- R3: While only one output is high, it stays high until the other output also goes high. The block has three resting conditions: neither output high, only up high (reference leading), and only down high (feedback leading).
- R4: Once both outputs are high, they stay high together for exactly RESET_DLY cycles (default 2, minimum 1). They then fall on the same edge, and neither falls without the other.
- R5: For input edges that are L cycles apart, the leading side's pulse lasts L + RESET_DLY cycles and the lagging side's pulse lasts RESET_DLY cycles.
- R6: A rising edge that is detected while both outputs are high is discarded. It does not set a flag after the common clear.
- R7: `idle_o` is high exactly when `up_o` and `dn_o` are both low.
- R8: When `rst_n` goes low, both outputs go low at once, without waiting for a clock edge. Reset is released inside the block two clock edges after `rst_n` rises.
- R9: When the feedback frequency is higher than the reference frequency, `dn_o` is high for more cycles in total than `up_o`. When the feedback frequency is lower, the opposite holds.
- R10: Rising edges detected in the same cycle on both inputs make both outputs high together, each for exactly RESET_DLY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both inputs |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| ref_in | input | 1 | Reference square wave (asynchronous) |
| fb_in | input | 1 | Divided feedback square wave (asynchronous) |
| up_o | output | 1 | High while the reference leads, plus the overlap time |
| dn_o | output | 1 | High while the feedback leads, plus the overlap time |
| idle_o | output | 1 | High when both outputs are low |

## Verification
The outputs are the registered lead flags themselves, so any wrong internal state shows up at the ports within a cycle or two:
- A flag stuck high shows as `idle_o` never returning.
- A miscounted overlap shows as a both-high window of the wrong length on the edge where the pulses should end.
- A re-armed flag shows as a stray pulse right after the common clear.

A counter that fails to start or stop makes every later pulse width wrong, so the width checks against known phase offsets expose it within one input period.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Condition of the detector, decoded from the two lead flags.
  typedef enum logic [1:0] {
    PFD_IDLE     = 2'd0,
    PFD_REF_LEAD = 2'd1,
    PFD_FB_LEAD  = 2'd2,
    PFD_OVERLAP  = 2'd3
  } pfd_state_e;

  function automatic pfd_state_e pfd_decode(input logic up, input logic dn);
    return pfd_state_e'({dn, up});
  endfunction

  // Width of a counter that must hold values 0 .. max_val.
  function automatic int pfd_cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);

  // pipe[0 .. STAGES-1] form the synchroniser; pipe[STAGES] holds the previous sample.
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
  parameter int RESET_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic both_hi_i,
  output logic clr_o
);

  localparam int CW = pfd_pkg::pfd_cnt_width(RESET_DLY);
  localparam logic [CW-1:0] LAST = CW'(RESET_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Clear fires in the last cycle of the overlap window.
  assign clr_o = both_hi_i && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!both_hi_i || clr_o) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: the count never passes the overlap length while both flags are high.
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    both_hi_i |-> (int'(cnt_q) < RESET_DLY));

  // R4: when the overlap starts, the count begins from zero.
  a_r4_count_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(both_hi_i) |-> (cnt_q == '0));

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
  parameter int RESET_DLY   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_o,
  output logic dn_o,
  output logic idle_o
);
  import pfd_pkg::*;

  localparam int NSIDE = 2;

  // Reset: assert at once, release after two clock edges.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  // Synchronise both inputs and detect their rising edges.
  logic [NSIDE-1:0] raw_in;
  logic [NSIDE-1:0] rise;

  assign raw_in = {fb_in, ref_in};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .d_i    (raw_in[g]),
      .rise_o (rise[g])
    );
  end

  // Lead flags.
  logic       up_q, dn_q, up_d, dn_d;
  logic       flag_en;
  logic       both_hi;
  logic       clr;
  pfd_state_e state;

  assign both_hi = up_q & dn_q;
  assign state   = pfd_decode(up_q, dn_q);

  pfd_clear_timer #(.RESET_DLY(RESET_DLY)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .both_hi_i (both_hi),
    .clr_o     (clr)
  );

  always_comb begin
    up_d    = up_q;
    dn_d    = dn_q;
    flag_en = 1'b0;
    if (clr) begin
      up_d    = 1'b0;
      dn_d    = 1'b0;
      flag_en = 1'b1;
    end else if (!both_hi) begin
      if (rise[0]) up_d = 1'b1;
      if (rise[1]) dn_d = 1'b1;
      flag_en = |rise;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (flag_en) begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign idle_o = (state == PFD_IDLE);

  // R1: a reference edge seen while the feedback side is low sets the up flag.
  a_r1_ref_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise[0] && !dn_q) |=> up_q);

  // R2: a feedback edge seen while the reference side is low sets the down flag.
  a_r2_fb_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise[1] && !up_q) |=> dn_q);

  // R3: a leading flag is held until the other flag arrives.
  a_r3_ref_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == PFD_REF_LEAD) |=> up_q);
  a_r3_fb_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == PFD_FB_LEAD) |=> dn_q);

  // R4: both flags always fall together.
  a_r4_fall_together: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(up_q) |-> $fell(dn_q));

  // R6: after an overlap the detector never leaves exactly one flag set.
  a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_int_n)
    both_hi |=> !(up_q ^ dn_q));

endmodule

// File: tb/test_pfd_tristate.sv
module test_pfd_tristate;

  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_in, fb_in;
  logic up_o, dn_o, idle_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  pfd_tristate #(.RESET_DLY(DLY)) i_pfd_tristate (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .up_o   (up_o),
    .dn_o   (dn_o),
    .idle_o (idle_o)
  );

  // Behavioural reference model.
  bit hr[$];
  bit hf[$];
  bit eu, ed;
  int ov;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr = '{0, 0, 0, 0};
      hf = '{0, 0, 0, 0};
      eu = 0;
      ed = 0;
      ov = 0;
    end else begin
      bit rr, fr;
      hr.push_back(ref_in);
      void'(hr.pop_front());
      hf.push_back(fb_in);
      void'(hf.pop_front());
      rr = hr[1] && !hr[0];
      fr = hf[1] && !hf[0];
      if (eu && ed) begin
        ov++;
        if (ov == DLY) begin
          eu = 0;
          ed = 0;
          ov = 0;
        end
      end else begin
        if (rr) eu = 1;
        if (fr) ed = 1;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison and pulse measurement.
  int up_run, dn_run, last_up, last_dn, up_tot, dn_tot;

  initial begin
    up_run = 0; dn_run = 0; last_up = 0; last_dn = 0; up_tot = 0; dn_tot = 0;
    forever begin
      @(posedge clk);
      #2;
      check(up_o == eu, "model up (R1 R3 R4 R6)", int'(up_o), int'(eu));
      check(dn_o == ed, "model dn (R2 R3 R4 R6)", int'(dn_o), int'(ed));
      check(idle_o == (!eu && !ed), "idle flag R7", int'(idle_o), int'(!eu && !ed));
      if (up_o) begin
        up_run++;
        up_tot++;
      end else if (up_run > 0) begin
        last_up = up_run;
        up_run  = 0;
      end
      if (dn_o) begin
        dn_run++;
        dn_tot++;
      end else if (dn_run > 0) begin
        last_dn = dn_run;
        dn_run  = 0;
      end
    end
  end

  task automatic run_waves(input int n, input int pr, input int pf, input int fdel);
    up_tot = 0;
    dn_tot = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      ref_in = ((c % pr) < pr / 2);
      fb_in  = (((c - fdel + 1000 * pf) % pf) < pf / 2);
    end
  endtask

  task automatic go_low(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      ref_in = 1'b0;
      fb_in  = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (R1 R9) actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(!up_o && !dn_o && idle_o, "reset state R8", int'({up_o, dn_o, idle_o}), 1);
    @(negedge clk);
    rst_n = 1'b1;
    go_low(8);

    // R5: the reference leads by 5 cycles.
    run_waves(400, 40, 40, 5);
    check(last_up == 5 + DLY, "R5 ref-lead up width", last_up, 5 + DLY);
    check(last_dn == DLY, "R5 ref-lead dn width", last_dn, DLY);
    go_low(40);

    // R5: the feedback leads by 6 cycles.
    run_waves(400, 40, 40, -6);
    check(last_dn == 6 + DLY, "R5 fb-lead dn width", last_dn, 6 + DLY);
    check(last_up == DLY, "R5 fb-lead up width", last_up, DLY);
    go_low(40);

    // R10: the edges are simultaneous.
    run_waves(400, 40, 40, 0);
    check(last_up == DLY, "R10 zero-lead up width", last_up, DLY);
    check(last_dn == DLY, "R10 zero-lead dn width", last_dn, DLY);
    go_low(40);

    // R9: the sign of a frequency difference.
    run_waves(1200, 40, 30, 0);
    check(dn_tot > up_tot, "R9 fast feedback dn dominates", dn_tot, up_tot);
    go_low(40);
    run_waves(1200, 30, 40, 0);
    check(up_tot > dn_tot, "R9 slow feedback up dominates", up_tot, dn_tot);
    go_low(40);

    // R6: a reference edge that arrives during the overlap is discarded.
    @(negedge clk); ref_in = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); fb_in = 1'b1;
    @(negedge clk); ref_in = 1'b0;
    @(negedge clk); ref_in = 1'b1;
    repeat (10) @(negedge clk);
    #6;
    check(!up_o && !dn_o, "R6 edge during overlap ignored", int'({up_o, dn_o}), 0);
    go_low(10);

    // R1 latency: the reference is sampled high at edge k and up is high after edge k+2.
    @(negedge clk); ref_in = 1'b1;
    @(posedge clk); #2;  // edge k
    check(!up_o, "R1 latency k", int'(up_o), 0);
    @(posedge clk); #2;
    check(!up_o, "R1 latency k+1", int'(up_o), 0);
    @(posedge clk); #2;
    check(up_o, "R1 latency k+2", int'(up_o), 1);
    // R3: the reference keeps leading with no feedback edge.
    repeat (20) @(posedge clk);
    #2;
    check(up_o && !dn_o, "R3 lead held", int'({up_o, dn_o}), 2);

    // R2 latency.
    @(negedge clk); fb_in = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    check(!dn_o, "R2 latency k+1", int'(dn_o), 0);
    @(posedge clk); #2;
    check(dn_o, "R2 latency k+2", int'(dn_o), 1);

    // R8: reset asserted in the middle of a run.
    go_low(10);
    @(negedge clk); ref_in = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check(!up_o && !dn_o, "R8 async reset clears", int'({up_o, dn_o}), 0);
    go_low(4);
    rst_n = 1'b1;
    go_low(10);
    check(idle_o, "R8 idle after release", int'(idle_o), 1);

    finish_run();
  end

endmodule